// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours (24-hour), day of month, weekday, month with a century flag, and a two-digit year. A prescaler counts pulses of a 32.768 kHz clock enable and produces one tick per second. Each tick ripples through the fields. Every field rolls over at its own limit, and the day limit depends on the month and on the leap rule.

Software reaches the fields through a flat byte-wide register port. Writes take effect on the clock edge and reads are combinational. A halt bit freezes timekeeping and holds the prescaler at zero. Software can therefore load a new time while halted and release the bit at a known instant; the first second then completes exactly one full prescale period later. A sticky low-supply flag reports a supply dip. It is fed by a single digital comparator input and is cleared only by software.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read as follows:
  - address 0: 0x00
  - address 1: 0x80 (low-supply flag set, seconds 00)
  - minutes and hours: 00
  - day: 01
  - weekday: 0
  - month: 0x01 (century flag 0)
  - year: 00
- R2: Seconds advance by one after each PRESCALE pulses of `osc_en`. Cycles without `osc_en` do not count, whatever the gaps between pulses.
- R3: Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Hours roll from 23 to 00 and carry into the day.
- R4: The day rolls back to 01 and carries into the month after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February.
- R5: In February the day rolls over after 29 when the BCD year value is divisible by 4 (00 included), and after 28 otherwise.
- R6: The month (bits 4:0 of address 6) rolls from 12 to 01 and carries into the year (address 7). When the year rolls from 99 to 00, the century flag (bit 7 of address 6) is inverted.
- R7: The weekday (address 5, bits 2:0, 0 to 6) increments on every day rollover and wraps from 6 to 0, independently of the date.
- R8: While the halt bit (address 0, bit 0) is 1, no field advances and the prescaler is held at zero. After the bit is cleared, the first second completes only after a full PRESCALE pulses.
- R9: The low-supply flag (address 1, bit 7) is set by reset and by `vlow_in`. It stays set until software writes address 1 with bit 7 at 0, and `vlow_in` wins over a clearing write.
- R10: Register layout, with BCD in the low bits:
  - address 1: seconds in bits 6:0
  - address 2: minutes in bits 6:0
  - address 3: hours in bits 5:0
  - address 4: day in bits 5:0
  - Unimplemented bits ignore writes and read as 0.
  - Addresses 8 and above read 0 and ignore writes.
- R11: A register write in the same cycle as a carry into that field wins for the written field. The other fields advance normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle enable per 32.768 kHz period |
| vlow_in | input | 1 | Supply-below-threshold comparator output |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |

## Verification
Most faults in the carry chain stay hidden until a field reaches its limit. A wrong month-length or leap decision shows up only at the one second where the day reaches 28 to 31. The bench therefore loads each field one step short of its rollover and reads every register after a single second, so a wrong carry appears within one prescale period. A prescaler that is not cleared by halt shows up as a second completing early after release. A wrong sticky-flag path shows up on the next read of address 1.

// File: rtl/rtc_cal_pkg.sv
// Package: shared constants and BCD helper functions for the calendar counter.
// Assumes packed BCD values in 8-bit containers; all helpers are pure functions.
package rtc_cal_pkg;

    localparam int NUM_FIELDS = 7;

    // Field indices; register address of a field is its index plus one.
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_WDAY = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    // Increment a packed BCD byte by one (no upper wrap handling here).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap test on a BCD year: the two-digit value is divisible by four.
    function automatic logic is_leap(input logic [7:0] year_bcd);
        logic [6:0] bin;
        bin = 7'(year_bcd[7:4]) * 7'd10 + 7'(year_bcd[3:0]);
        return (bin[1:0] == 2'b00);
    endfunction

    // Last day of the month, in BCD, for a BCD month and BCD year.
    function automatic logic [7:0] month_last_day(input logic [4:0] mon_bcd,
                                                  input logic [7:0] year_bcd);
        case (mon_bcd)
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            5'h02:                      return is_leap(year_bcd) ? 8'h29 : 8'h28;
            default:                    return 8'h31;
        endcase
    endfunction

    // Implemented bits of each field's register.
    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            F_SEC, F_MIN:   return 8'h7F;
            F_HOUR, F_DAY:  return 8'h3F;
            F_WDAY:         return 8'h07;
            F_MON:          return 8'h1F;
            default:        return 8'hFF;
        endcase
    endfunction

    // Lowest legal value of a field, which is also its reset value.
    function automatic logic [7:0] field_floor(input int idx);
        case (idx)
            F_DAY, F_MON: return 8'h01;
            default:      return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Module: sub-second prescaler. Counts osc_en pulses and emits a one-cycle
// second tick on the pulse that completes DIV counts. Assumes osc_en is a
// single-cycle enable; halt holds the count at zero and suppresses ticks.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic halt,
    output logic sec_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Tick on the enable pulse that completes the division.
    assign sec_tick = osc_en && !halt && (cnt == LAST);

    // Count enable pulses; halt clears all sub-second state.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            cnt <= '0;
        end else if (osc_en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !halt) |=> $stable(cnt));
    p_halt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (cnt == '0));

endmodule

// File: rtl/rtc_bcd_field.sv
// Module: one BCD time/calendar field. Advances on inc, wraps to MIN_VAL when
// its current value equals max_val, and reports carry in that cycle. A write
// overrides the increment. Assumes max_val is already in BCD form.
module rtc_bcd_field
    import rtc_cal_pkg::*;
#(
    parameter logic [7:0] MASK    = 8'hFF,
    parameter logic [7:0] MIN_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic [7:0] max_val,
    output logic [7:0] val,
    output logic       carry
);
    // Carry out when an increment hits the upper limit.
    assign carry = inc && (val == max_val);

    // Load on write, else wrap or step on increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= MIN_VAL;
        end else if (wr) begin
            val <= wdata & MASK;
        end else if (inc) begin
            val <= (val == max_val) ? MIN_VAL : (bcd_inc(val) & MASK);
        end
    end

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && (val == max_val)) |=> (val == MIN_VAL));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr) |=> $stable(val));
    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (val & ~MASK) == 8'h00);

endmodule

// File: rtl/rtc_calendar_core.sv
// Module: top of the BCD calendar counter. Instantiates the prescaler and one
// field per time unit, chains their carries, keeps the halt, century and
// low-supply bits, and decodes the flat register port.
// Assumes one register access per cycle; reads are combinational.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int PRESCALE = 32768,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              vlow_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    localparam int A_CTRL  = 0;
    localparam int A_FIRST = 1;
    localparam int A_SECS  = A_FIRST + F_SEC;
    localparam int A_MONTH = A_FIRST + F_MON;
    localparam int A_LAST  = A_FIRST + NUM_FIELDS - 1;

    logic                  halt_q;
    logic                  vl_q;
    logic                  cent_q;
    logic                  sec_tick;
    logic [7:0]            fval [NUM_FIELDS];
    logic [7:0]            fmax [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] finc;
    logic [NUM_FIELDS-1:0] fcarry;
    logic [NUM_FIELDS-1:0] fwr;

    rtc_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .halt     (halt_q),
        .sec_tick (sec_tick)
    );

    // Upper limit of each field; the day limit follows month and leap year.
    always_comb begin
        fmax[F_SEC]  = 8'h59;
        fmax[F_MIN]  = 8'h59;
        fmax[F_HOUR] = 8'h23;
        fmax[F_DAY]  = month_last_day(fval[F_MON][4:0], fval[F_YEAR]);
        fmax[F_WDAY] = 8'h06;
        fmax[F_MON]  = 8'h12;
        fmax[F_YEAR] = 8'h99;
    end

    // Carry chain; weekday steps with the day but never carries onward.
    always_comb begin
        finc[F_SEC]  = sec_tick;
        finc[F_MIN]  = fcarry[F_SEC];
        finc[F_HOUR] = fcarry[F_MIN];
        finc[F_DAY]  = fcarry[F_HOUR];
        finc[F_WDAY] = fcarry[F_HOUR];
        finc[F_MON]  = fcarry[F_DAY];
        finc[F_YEAR] = fcarry[F_MON];
    end

    genvar g;
    generate
        for (g = 0; g < NUM_FIELDS; g++) begin : g_field
            assign fwr[g] = reg_wr && (int'(reg_addr) == A_FIRST + g);

            rtc_bcd_field #(
                .MASK    (field_mask(g)),
                .MIN_VAL (field_floor(g))
            ) u_field (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (finc[g]),
                .wr      (fwr[g]),
                .wdata   (reg_wdata),
                .max_val (fmax[g]),
                .val     (fval[g]),
                .carry   (fcarry[g])
            );
        end
    endgenerate

    // Halt bit: software-controlled freeze of timekeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (reg_wr && int'(reg_addr) == A_CTRL) begin
            halt_q <= reg_wdata[0];
        end
    end

    // Century flag: written with the month, inverted on year rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cent_q <= 1'b0;
        end else if (fwr[F_MON]) begin
            cent_q <= reg_wdata[7];
        end else if (fcarry[F_YEAR]) begin
            cent_q <= ~cent_q;
        end
    end

    // Low-supply flag: set by reset or comparator, cleared only by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q <= 1'b1;
        end else begin
            vl_q <= vlow_in | (fwr[F_SEC] ? reg_wdata[7] : vl_q);
        end
    end

    // Register read decode; unimplemented bits and addresses read zero.
    always_comb begin
        reg_rdata = 8'h00;
        if (int'(reg_addr) == A_CTRL) begin
            reg_rdata = {7'd0, halt_q};
        end else if (int'(reg_addr) == A_SECS) begin
            reg_rdata = {vl_q, fval[F_SEC][6:0]};
        end else if (int'(reg_addr) == A_MONTH) begin
            reg_rdata = {cent_q, 2'b00, fval[F_MON][4:0]};
        end else if (int'(reg_addr) > A_FIRST && int'(reg_addr) <= A_LAST) begin
            reg_rdata = fval[int'(reg_addr) - A_FIRST];
        end
    end

    p_vl_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vlow_in |=> vl_q);
    p_vl_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_q && !fwr[F_SEC]) |=> vl_q);
    p_century_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fcarry[F_YEAR] && !fwr[F_MON]) |=> (cent_q != $past(cent_q)));
    p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !reg_wr) |=> $stable(fval[F_SEC]) && $stable(fval[F_MIN]));
    p_wday_follows_day_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (finc[F_DAY] && !fwr[F_WDAY] && fval[F_WDAY] == 8'h06) |=> (fval[F_WDAY] == 8'h00));

endmodule

// File: tb/tb_rtc_calendar_core.sv
// Bench: vector table of one-second rollovers, then directed tests.
module tb_rtc_calendar_core;
    localparam int PRE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       vlow_in = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_calendar_core #(.PRESCALE(PRE), .ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .vlow_in(vlow_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [7:0] s, m, h, d, w, mo, y;
        logic [7:0] es, em, eh, ed, ew, emo, ey;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'h00,8'h00,8'h00,8'h01,8'h0,8'h01,8'h00, 8'h01,8'h00,8'h00,8'h01,8'h0,8'h01,8'h00},
        '{8'h59,8'h34,8'h12,8'h15,8'h3,8'h06,8'h21, 8'h00,8'h35,8'h12,8'h15,8'h3,8'h06,8'h21},
        '{8'h59,8'h59,8'h10,8'h15,8'h3,8'h06,8'h21, 8'h00,8'h00,8'h11,8'h15,8'h3,8'h06,8'h21},
        '{8'h59,8'h59,8'h23,8'h15,8'h3,8'h06,8'h21, 8'h00,8'h00,8'h00,8'h16,8'h4,8'h06,8'h21},
        '{8'h59,8'h59,8'h23,8'h30,8'h6,8'h04,8'h21, 8'h00,8'h00,8'h00,8'h01,8'h0,8'h05,8'h21},
        '{8'h59,8'h59,8'h23,8'h30,8'h2,8'h05,8'h21, 8'h00,8'h00,8'h00,8'h31,8'h3,8'h05,8'h21},
        '{8'h59,8'h59,8'h23,8'h31,8'h1,8'h01,8'h21, 8'h00,8'h00,8'h00,8'h01,8'h2,8'h02,8'h21},
        '{8'h59,8'h59,8'h23,8'h28,8'h0,8'h02,8'h21, 8'h00,8'h00,8'h00,8'h01,8'h1,8'h03,8'h21},
        '{8'h59,8'h59,8'h23,8'h28,8'h5,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h29,8'h6,8'h02,8'h24},
        '{8'h59,8'h59,8'h23,8'h29,8'h6,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h01,8'h0,8'h03,8'h24},
        '{8'h59,8'h59,8'h23,8'h28,8'h4,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h29,8'h5,8'h02,8'h00},
        '{8'h59,8'h59,8'h23,8'h31,8'h3,8'h12,8'h98, 8'h00,8'h00,8'h00,8'h01,8'h4,8'h01,8'h99},
        '{8'h59,8'h59,8'h23,8'h31,8'h4,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h5,8'h81,8'h00},
        '{8'h59,8'h59,8'h23,8'h31,8'h4,8'h92,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h5,8'h01,8'h00},
        '{8'h59,8'h59,8'h23,8'h30,8'h2,8'h09,8'h19, 8'h00,8'h00,8'h00,8'h01,8'h3,8'h10,8'h19},
        '{8'h59,8'h59,8'h23,8'h31,8'h5,8'h07,8'h20, 8'h00,8'h00,8'h00,8'h01,8'h6,8'h08,8'h20},
        '{8'h59,8'h59,8'h23,8'h30,8'h1,8'h11,8'h22, 8'h00,8'h00,8'h00,8'h01,8'h2,8'h12,8'h22},
        '{8'h59,8'h59,8'h23,8'h31,8'h1,8'h10,8'h22, 8'h00,8'h00,8'h00,8'h01,8'h2,8'h11,8'h22}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_en = 1'b1;
            @(negedge clk); osc_en = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register
        rd(0, v); check("R1 ctrl", v, 8'h00);
        rd(1, v); check("R1 seconds+R9 flag", v, 8'h80);
        rd(2, v); check("R1 minutes", v, 8'h00);
        rd(3, v); check("R1 hours", v, 8'h00);
        rd(4, v); check("R1 day", v, 8'h01);
        rd(5, v); check("R1 weekday", v, 8'h00);
        rd(6, v); check("R1 month", v, 8'h01);
        rd(7, v); check("R1 year", v, 8'h00);

        // R10: masked writes and unmapped addresses
        wr(5, 8'hFF); rd(5, v); check("R10 weekday mask", v, 8'h07);
        wr(3, 8'hFF); rd(3, v); check("R10 hours mask", v, 8'h3F);
        wr(0, 8'hFE); rd(0, v); check("R10 ctrl mask", v, 8'h00);
        wr(6, 8'h7F); rd(6, v); check("R10 month mask", v, 8'h1F);
        wr(9, 8'h55); rd(9, v); check("R10 unmapped", v, 8'h00);
        rd(2, v); check("R10 unmapped write no effect", v, 8'h00);

        // R2: gapped enable pulses, one second per PRE pulses
        wr(0, 8'h01); wr(1, 8'h10); wr(3, 8'h00); wr(0, 8'h00);
        pulse(PRE - 1, 1);
        rd(1, v); check("R2 before full count", v, 8'h10);
        repeat (5) @(negedge clk);
        rd(1, v); check("R2 idle cycles ignored", v, 8'h10);
        pulse(1, 2);
        rd(1, v); check("R2 after full count", v, 8'h11);

        // R8: halt freezes time and clears the prescaler
        pulse(2, 0);
        wr(0, 8'h01);
        pulse(10, 0);
        rd(1, v); check("R8 frozen while halted", v, 8'h11);
        rd(0, v); check("R8 halt readback", v, 8'h01);
        wr(0, 8'h00);
        pulse(PRE - 1, 0);
        rd(1, v); check("R8 prescaler cleared", v, 8'h11);
        pulse(1, 0);
        rd(1, v); check("R8 resumes", v, 8'h12);

        // R9: sticky low-supply flag
        rd(1, v); check("R9 cleared by earlier write", v, 8'h12);
        @(negedge clk); vlow_in = 1'b1;
        @(negedge clk); vlow_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(1, v); check("R9 set and sticky", v, 8'h92);
        wr(3, 8'h05);
        rd(1, v); check("R9 other write keeps flag", v, 8'h92);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 8'h12; vlow_in = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; vlow_in = 1'b0;
        rd(1, v); check("R9 comparator beats clear", v, 8'h92);
        wr(1, 8'h12);
        rd(1, v); check("R9 software clear", v, 8'h12);

        // R11: write to minutes coincides with the carry from seconds
        wr(0, 8'h01); wr(1, 8'h59); wr(2, 8'h10); wr(3, 8'h05); wr(0, 8'h00);
        pulse(PRE - 1, 0);
        @(negedge clk);
        osc_en = 1'b1; reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 8'h20;
        @(negedge clk);
        osc_en = 1'b0; reg_wr = 1'b0;
        rd(1, v); check("R11 seconds wrapped", v, 8'h00);
        rd(2, v); check("R11 write wins", v, 8'h20);
        rd(3, v); check("R11 hours untouched", v, 8'h05);

        // R2/R3/R4/R5/R6/R7: one-second rollover vectors
        for (int k = 0; k < NV; k++) begin
            string t;
            t = $sformatf("R2/R3/R4/R5/R6/R7 vec %0d", k);
            wr(0, 8'h01);
            wr(1, VECS[k].s); wr(2, VECS[k].m); wr(3, VECS[k].h);
            wr(4, VECS[k].d); wr(5, VECS[k].w); wr(6, VECS[k].mo);
            wr(7, VECS[k].y);
            wr(0, 8'h00);
            pulse(PRE, 0);
            rd(1, v); check({t, " sec"}, v, VECS[k].es);
            rd(2, v); check({t, " min"}, v, VECS[k].em);
            rd(3, v); check({t, " hour"}, v, VECS[k].eh);
            rd(4, v); check({t, " day"}, v, VECS[k].ed);
            rd(5, v); check({t, " wday"}, v, VECS[k].ew);
            rd(6, v); check({t, " month"}, v, VECS[k].emo);
            rd(7, v); check({t, " year"}, v, VECS[k].ey);
        end

        summary();
    end
endmodule